// File: doc/BRIEF.md
# Integer compare-and-set-predicate unit

This unit evaluates one integer comparison per cycle and turns it into two 1-bit predicate results. It decodes a 64-bit instruction word. The word supplies a compare condition, a signedness flag, a boolean combining operator, a source predicate with an optional inversion, two destination predicate indices and the register index of operand A. The index of operand A is driven out so that the surrounding register file can return the value. Both 32-bit operands arrive on input ports in the same cycle as the instruction.

The unit holds its own eight-entry predicate file. The comparison outcome is merged with the source predicate by the selected operator, and the result goes to the primary destination. The inverted comparison is merged in the same way, and that result goes to the secondary destination. Both writes take effect at the clock edge that ends the issue cycle. A separate read port lets the surrounding logic observe any predicate. Predicate 7 is a constant true entry. The reserved combining code flags the instruction as illegal and suppresses both writes.

Top module: `cmpset_unit`

## Requirements
- R1: The compare condition sits in instruction bits [51:49]. It is coded 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always, and the test is A against B.
- R2: Instruction bit 48 set makes the ordered compare conditions treat A and B as two's-complement numbers. When the bit is clear, they are compared as unsigned numbers.
- R3: Instruction bits [46:45] select the combining operator: 0 AND, 1 OR, 2 XOR.
- R4: Instruction bits [41:39] give the index of the source predicate. When instruction bit 42 is set, that predicate is inverted before it is combined.
- R5: The primary destination, at instruction bits [5:3], receives the comparison combined with the source predicate. The secondary destination, at bits [2:0], receives the inverted comparison combined with the same predicate.
- R6: The output a_idx always equals instruction bits [15:8].
- R7: Predicate 7 always reads as true, and any write to it is discarded.
- R8: Combining code 3 raises illegal during the issue cycle and blocks both predicate writes. Every other combining code keeps illegal low.
- R9: When both destinations name the same predicate, that predicate takes the primary destination's value.
- R10: After reset, predicates 0 to 6 read false and predicate 7 reads true. Writes land at the clock edge that ends the issue cycle, and the combinational read port rd_idx/rd_val shows them from then on.
- R11: While issue is low, no predicate changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction valid this cycle |
| insn | input | 64 | Instruction word |
| a_val | input | 32 | Operand A value fetched by the caller |
| b_val | input | 32 | Operand B value |
| a_idx | output | 8 | Register index of operand A |
| illegal | output | 1 | Reserved combining code seen on an issued instruction |
| rd_idx | input | 3 | Predicate read index |
| rd_val | output | 1 | Predicate read value |

## Verification
On every cycle, the assertions check the following. The predicate file holds still when issue is low or when the instruction is illegal. Predicate 7 reads true. The primary write wins when both destinations collide. The two combined results keep the relation that their operator forces, for example that XOR results always differ. A less-than between operands of opposite sign follows the sign bit that signedness selects. Only the bench's scenarios can show the following. Each compare code yields the correct outcome on chosen operand pairs. The operator and inversion fields pick the intended source predicate and operation. The exact reset contents and the timing of writes on the read port also need the scenarios.

// File: rtl/cmpset_pkg.sv
package cmpset_pkg;

    localparam int PRED_N  = 8;
    localparam int PIDX_W  = $clog2(PRED_N);
    localparam int RIDX_W  = 8;

    // instruction field positions
    localparam int F_DST_S = 0;
    localparam int F_DST_P = 3;
    localparam int F_AIDX  = 8;
    localparam int F_SRCP  = 39;
    localparam int F_SINV  = 42;
    localparam int F_COMB  = 45;
    localparam int F_SGN   = 48;
    localparam int F_COND  = 49;
    localparam int F_TOP   = 52;

    typedef enum logic [2:0] {
        C_NEVER  = 3'd0,
        C_LT     = 3'd1,
        C_EQ     = 3'd2,
        C_LE     = 3'd3,
        C_GT     = 3'd4,
        C_NE     = 3'd5,
        C_GE     = 3'd6,
        C_ALWAYS = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        B_AND = 2'd0,
        B_OR  = 2'd1,
        B_XOR = 2'd2,
        B_RSV = 2'd3
    } bop_e;

    typedef struct packed {
        cond_e              cond;
        logic               sgn;
        bop_e               bop;
        logic [PIDX_W-1:0]  src_p;
        logic               src_inv;
        logic [PIDX_W-1:0]  dst_p;
        logic [PIDX_W-1:0]  dst_s;
        logic [RIDX_W-1:0]  a_idx;
    } fields_t;

    function automatic logic merge(input bop_e op, input logic x, input logic y);
        case (op)
            B_AND:   merge = x & y;
            B_OR:    merge = x | y;
            B_XOR:   merge = x ^ y;
            default: merge = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmpset_decode.sv
module cmpset_decode
    import cmpset_pkg::*;
#(
    parameter int INSN_W = 64
) (
    input  logic [INSN_W-1:0] insn,
    output fields_t           f
);
    logic unused_bits;
    assign unused_bits = ^{insn[INSN_W-1:F_TOP], insn[F_SGN-1], insn[F_COMB-1:F_SINV+1],
                           insn[F_SRCP-1:F_AIDX+RIDX_W], insn[F_AIDX-1:F_DST_P+PIDX_W]};

    always_comb begin
        f.cond    = cond_e'(insn[F_COND +: 3]);
        f.sgn     = insn[F_SGN];
        f.bop     = bop_e'(insn[F_COMB +: 2]);
        f.src_p   = insn[F_SRCP +: PIDX_W];
        f.src_inv = insn[F_SINV];
        f.dst_p   = insn[F_DST_P +: PIDX_W];
        f.dst_s   = insn[F_DST_S +: PIDX_W];
        f.a_idx   = insn[F_AIDX +: RIDX_W];
    end
endmodule

// File: rtl/cmpset_eval.sv
module cmpset_eval
    import cmpset_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  cond_e             cond,
    input  logic              sgn,
    input  bop_e              bop,
    input  logic              pin,
    output logic              res_p,
    output logic              res_s
);
    localparam int MSB = DATA_W - 1;

    logic eq, lt, hit;

    always_comb begin
        eq = (a == b);
        if (sgn) lt = ($signed(a) < $signed(b));
        else     lt = (a < b);
        case (cond)
            C_NEVER:  hit = 1'b0;
            C_LT:     hit = lt;
            C_EQ:     hit = eq;
            C_LE:     hit = lt | eq;
            C_GT:     hit = ~(lt | eq);
            C_NE:     hit = ~eq;
            C_GE:     hit = ~lt;
            default:  hit = 1'b1;
        endcase
        res_p = merge(bop, hit, pin);
        res_s = merge(bop, ~hit, pin);
    end

    always_comb begin
        // R2
        if (cond == C_LT && a[MSB] != b[MSB])
            sign_lt_chk: assert (hit == (sgn ? a[MSB] : b[MSB]));
        // R5
        if (bop == B_XOR)
            xor_pair_chk: assert (res_p != res_s);
        // R5
        if (bop == B_AND)
            and_pair_chk: assert (!(res_p && res_s));
        // R5
        if (bop == B_OR)
            or_pair_chk: assert (res_p || res_s);
    end
endmodule

// File: rtl/cmpset_pfile.sv
module cmpset_pfile
    import cmpset_pkg::*;
#(
    parameter int NUM = PRED_N,
    localparam int IW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we0,
    input  logic [IW-1:0] wi0,
    input  logic          wd0,
    input  logic          we1,
    input  logic [IW-1:0] wi1,
    input  logic          wd1,
    input  logic [IW-1:0] ri0,
    output logic          ro0,
    input  logic [IW-1:0] ri1,
    output logic          ro1,
    output logic [NUM-1:0] pvec
);
    localparam logic [NUM-1:0] RST_VEC = {1'b1, {(NUM-1){1'b0}}};

    logic [NUM-2:0] st;

    for (genvar i = 0; i < NUM - 1; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                             st[i] <= 1'b0;
            else if (we0 && wi0 == IW'(i))       st[i] <= wd0;
            else if (we1 && wi1 == IW'(i))       st[i] <= wd1;
        end
    end

    assign pvec = {1'b1, st};
    assign ro0  = pvec[ri0];
    assign ro1  = pvec[ri1];

    // R9
    dst_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (we0 && we1 && wi0 == wi1 && wi0 != IW'(NUM-1)) |=> pvec[$past(wi0)] == $past(wd0));
    // R10
    rst_val_chk: assert property (@(posedge clk) rst |=> pvec == RST_VEC);
endmodule

// File: rtl/cmpset_unit.sv
module cmpset_unit
    import cmpset_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INSN_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [RIDX_W-1:0] a_idx,
    output logic              illegal,
    input  logic [PIDX_W-1:0] rd_idx,
    output logic              rd_val
);
    fields_t           f;
    logic              src_raw, pin, res_p, res_s, wr;
    logic [PRED_N-1:0] pvec;

    cmpset_decode #(.INSN_W(INSN_W)) u_dec (.insn(insn), .f(f));

    cmpset_eval #(.DATA_W(DATA_W)) u_eval (
        .a(a_val), .b(b_val), .cond(f.cond), .sgn(f.sgn), .bop(f.bop),
        .pin(pin), .res_p(res_p), .res_s(res_s)
    );

    cmpset_pfile #(.NUM(PRED_N)) u_pf (
        .clk(clk), .rst(rst),
        .we0(wr), .wi0(f.dst_p), .wd0(res_p),
        .we1(wr), .wi1(f.dst_s), .wd1(res_s),
        .ri0(f.src_p), .ro0(src_raw),
        .ri1(rd_idx), .ro1(rd_val),
        .pvec(pvec)
    );

    assign pin     = src_raw ^ f.src_inv;
    assign a_idx   = f.a_idx;
    assign illegal = issue && (f.bop == B_RSV);
    assign wr      = issue && (f.bop != B_RSV);

    // R8
    ill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> pvec == $past(pvec));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(pvec));
    // R7
    top_true_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == PIDX_W'(PRED_N-1)) |-> rd_val);
endmodule

// File: tb/sim_cmpset_unit.sv
module sim_cmpset_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [63:0] insn = '0;
    logic [31:0] a_val = '0, b_val = '0;
    logic [7:0]  a_idx;
    logic        illegal;
    logic [2:0]  rd_idx = '0;
    logic        rd_val;

    int checks = 0, failures = 0;
    logic done = 1'b0;
    logic ill_seen;

    always #4 clk = ~clk;

    cmpset_unit u0 (
        .clk(clk), .rst(rst), .issue(issue), .insn(insn), .a_val(a_val), .b_val(b_val),
        .a_idx(a_idx), .illegal(illegal), .rd_idx(rd_idx), .rd_val(rd_val)
    );

    function automatic logic [63:0] mk(input logic [2:0] cnd, input logic sg, input logic [1:0] op,
                                       input logic [2:0] sp, input logic inv,
                                       input logic [2:0] dp, input logic [2:0] ds,
                                       input logic [7:0] ai);
        logic [63:0] w = '0;
        w[51:49] = cnd; w[48] = sg; w[46:45] = op; w[41:39] = sp; w[42] = inv;
        w[5:3] = dp; w[2:0] = ds; w[15:8] = ai;
        return w;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] idx, input logic exp, input string tag);
        rd_idx = idx;
        #1;
        chk(rd_val, exp, tag);
    endtask

    task automatic run(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic iss);
        @(negedge clk);
        issue = iss; insn = w; a_val = a; b_val = b;
        #1 ill_seen = illegal;
        @(negedge clk);
        issue = 1'b0;
    endtask

    // {cond, signed, a, b, expected comparison}
    localparam logic [68:0] VEC [14] = '{
        {3'd1, 1'b0, 32'd5,         32'd9,         1'b1},
        {3'd1, 1'b0, 32'hFFFFFFFF,  32'd1,         1'b0},
        {3'd1, 1'b1, 32'hFFFFFFFF,  32'd1,         1'b1},
        {3'd2, 1'b0, 32'd7,         32'd7,         1'b1},
        {3'd2, 1'b0, 32'd7,         32'd8,         1'b0},
        {3'd3, 1'b0, 32'd8,         32'd8,         1'b1},
        {3'd4, 1'b1, 32'd1,         32'hFFFFFFFF,  1'b1},
        {3'd4, 1'b0, 32'd1,         32'hFFFFFFFF,  1'b0},
        {3'd5, 1'b0, 32'd3,         32'd4,         1'b1},
        {3'd6, 1'b1, 32'h80000000,  32'd0,         1'b0},
        {3'd6, 1'b0, 32'h80000000,  32'd0,         1'b1},
        {3'd0, 1'b0, 32'd1,         32'd1,         1'b0},
        {3'd7, 1'b0, 32'd1,         32'd2,         1'b1},
        {3'd3, 1'b1, 32'h80000000,  32'h7FFFFFFF,  1'b1}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset contents
        for (int i = 0; i < 8; i++) rd_chk(3'(i), (i == 7), "R10 reset value");

        // R6 operand A index
        insn = mk(3'd0, 1'b0, 2'd0, 3'd7, 1'b0, 3'd1, 3'd2, 8'hA5);
        #1; checks++;
        if (a_idx !== 8'hA5) begin
            failures++; $display("FAIL R6 actual=%0h expected=a5", a_idx);
        end

        // R1 R2 R5: AND with predicate 7, primary 1 gets cmp, secondary 2 gets inverse
        for (int k = 0; k < 14; k++) begin
            run(mk(VEC[k][68:66], VEC[k][65], 2'd0, 3'd7, 1'b0, 3'd1, 3'd2, 8'd0),
                VEC[k][64:33], VEC[k][32:1], 1'b1);
            rd_chk(3'd1, VEC[k][0], "R1/R2 primary compare");
            rd_chk(3'd2, ~VEC[k][0], "R5 secondary inverse");
            chk(ill_seen, 1'b0, "R8 legal no illegal");
        end

        // R8 reserved operator blocks writes (would give 1=0, 2=1)
        run(mk(3'd0, 1'b0, 2'd3, 3'd7, 1'b0, 3'd1, 3'd2, 8'd0), 32'd0, 32'd0, 1'b1);
        chk(ill_seen, 1'b1, "R8 illegal flag");
        rd_chk(3'd1, 1'b1, "R8 primary held");
        rd_chk(3'd2, 1'b0, "R8 secondary held");

        // R11 no issue -> no change (would give 2=1, 1=0)
        run(mk(3'd7, 1'b0, 2'd0, 3'd7, 1'b0, 3'd2, 3'd1, 8'd0), 32'd0, 32'd0, 1'b0);
        rd_chk(3'd2, 1'b0, "R11 idle held");
        rd_chk(3'd1, 1'b1, "R11 idle held");

        // R3 operators with predicate 3 = 1
        run(mk(3'd2, 1'b0, 2'd0, 3'd7, 1'b0, 3'd3, 3'd4, 8'd0), 32'd7, 32'd7, 1'b1);
        rd_chk(3'd3, 1'b1, "R3 setup");
        run(mk(3'd0, 1'b0, 2'd1, 3'd3, 1'b0, 3'd5, 3'd6, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd5, 1'b1, "R3 OR primary");
        rd_chk(3'd6, 1'b1, "R3 OR secondary");
        run(mk(3'd7, 1'b0, 2'd2, 3'd3, 1'b0, 3'd5, 3'd6, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd5, 1'b0, "R3 XOR primary");
        rd_chk(3'd6, 1'b1, "R3 XOR secondary");

        // R4 source index and inversion
        run(mk(3'd7, 1'b0, 2'd0, 3'd3, 1'b1, 3'd5, 3'd6, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd5, 1'b0, "R4 inverted true source");
        rd_chk(3'd6, 1'b0, "R4 inverted true source");
        run(mk(3'd7, 1'b0, 2'd0, 3'd4, 1'b1, 3'd5, 3'd6, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd5, 1'b1, "R4 inverted false source");

        // R7 write to predicate 7 is discarded
        run(mk(3'd0, 1'b0, 2'd0, 3'd7, 1'b0, 3'd7, 3'd0, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd7, 1'b1, "R7 hardwired true");

        // R9 same destination: primary wins
        run(mk(3'd7, 1'b0, 2'd0, 3'd7, 1'b0, 3'd0, 3'd0, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd0, 1'b1, "R9 primary wins (1)");
        run(mk(3'd0, 1'b0, 2'd0, 3'd7, 1'b0, 3'd0, 3'd0, 8'd0), 32'd0, 32'd0, 1'b1);
        rd_chk(3'd0, 1'b0, "R9 primary wins (0)");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule